// File: doc/BRIEF.md
# Dual-Clock FIFO with Loadable Almost-Empty / Almost-Full Thresholds

This block is a first-in first-out buffer for 18-bit words. The write port and the read port each run on their own clock. Each port has an active-low enable, and each domain produces an active-low boundary flag: full on the write side and empty on the read side. It also produces an active-low "almost" flag whose threshold is held in a 16-bit offset register. Pointers cross between the domains as Gray code through two-flop synchronisers. A stale view of the other side's pointer can only make a flag assert early or deassert late, so neither overflow nor underflow is possible.

A shared active-low select input `cfg_sel_n` turns both ports from data traffic to threshold access. When it is low, each write-enabled write-clock edge loads the next offset register from `wdata[15:0]`. Each read-enabled read-clock edge puts the next offset register, zero-extended, onto the output register. Each port steps through the two registers in the same order: empty offset, then full offset, then empty offset again. A port can leave the sequence after any number of accesses by raising the select. The output bus goes to high impedance while the active-low output enable is high. A common active-low reset empties the FIFO, sets both offsets to depth/8 and rewinds both sequence positions.

Each port decodes its operation per edge with an enumerated operation type: `WOP_IDLE`, `WOP_PUSH` and `WOP_LOAD` on the write side, and `ROP_IDLE`, `ROP_POP` and `ROP_PEEK` on the read side. Each port keeps a sequence-position state machine with the states `SEL_EMPTY_OFS` and `SEL_FULL_OFS`. The transition `SEL_EMPTY_OFS -> SEL_FULL_OFS` and the transition `SEL_FULL_OFS -> SEL_EMPTY_OFS` both happen on every `WOP_LOAD` (write side) or `ROP_PEEK` (read side). Reset forces the state to `SEL_EMPTY_OFS`.

Top module: `pf_fifo_top`

## Requirements
- R1: After reset, `empty_n`=0, `full_n`=1, `aempty_n`=0, `afull_n`=1. The output register holds 0, and both offsets read back as DEPTH/8 (2 at the default depth 16).
- R2: With `cfg_sel_n`=1, `wen_n`=0 and `full_n`=1, the word on `wdata` is stored at the write-clock edge. With `cfg_sel_n`=1, `ren_n`=0 and `empty_n`=1, the oldest stored word appears on `rdata` after the read-clock edge. Words leave in the order they entered.
- R3: While `oe_n`=1, all 18 bits of `rdata` are high impedance. While `oe_n`=0, `rdata` shows the output register.
- R4: `full_n` is 0 while DEPTH words are stored. A write attempted while `full_n`=0 stores nothing.
- R5: `empty_n` is 0 while no word is stored. A read attempted while `empty_n`=0 removes nothing.
- R6: A read attempted while `empty_n`=0 leaves `rdata` at the last word read.
- R7: Each write edge with `cfg_sel_n`=0 and `wen_n`=0 loads `wdata[15:0]` into the offset register at the write sequence position. The first such edge after reset loads the empty offset, the second loads the full offset, and the loads keep alternating.
- R8: While `cfg_sel_n`=0, no word is stored or removed. Raising `cfg_sel_n` resumes data traffic. Each port's sequence position is kept until the next offset access or reset.
- R9: Each read edge with `cfg_sel_n`=0 and `ren_n`=0 puts the offset at the read sequence position on `rdata`, zero-extended in bits 17:16. The first access after reset reads the empty offset, and the accesses then alternate.
- R10: Once the FIFO is quiet, `aempty_n`=0 exactly when the stored word count is at or below the empty offset. This flag is updated on the read clock.
- R11: Once the FIFO is quiet, `afull_n`=0 exactly when DEPTH minus the stored word count is at or below the full offset. This flag is updated on the write clock.
- R12: `empty_n` is never 1 while no word is stored, and `full_n` is never 1 while DEPTH words are stored, on every edge and even with both ports busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Common active-low reset |
| wclk | input | 1 | Write-domain clock |
| wen_n | input | 1 | Active-low write enable |
| wdata | input | 18 | Write data, low 16 bits also load offsets |
| rclk | input | 1 | Read-domain clock |
| ren_n | input | 1 | Active-low read enable |
| cfg_sel_n | input | 1 | Active-low offset-access select, shared by both ports |
| oe_n | input | 1 | Active-low output enable |
| rdata | output | 18 | Read data / offset readback, high impedance when disabled |
| empty_n | output | 1 | Active-low empty flag, read clock |
| aempty_n | output | 1 | Active-low almost-empty flag, read clock |
| full_n | output | 1 | Active-low full flag, write clock |
| afull_n | output | 1 | Active-low almost-full flag, write clock |

## Verification
The FIFO is driven with a fill-to-full burst that includes extra writes past full. It is then drained with extra reads past empty, which separates blocked operations from accepted ones and shows the hold of the last word. Offset loads and readbacks are interleaved with stored data, so the bench can tell whether the select steals or injects FIFO words. They are also run in a partial sequence, which shows whether each port keeps its position. The almost-flag thresholds are crossed one word at a time to pin down the at-or-below boundary. A phase with both ports busy and their clocks offset compares every read word with a queue model. On each edge it also checks that a boundary flag is never missing while the model says empty or full.

// File: rtl/pf_fifo_pkg.sv
package pf_fifo_pkg;

    // Sequence position shared in meaning by the write and read ports
    typedef enum logic {
        SEL_EMPTY_OFS = 1'b0,
        SEL_FULL_OFS  = 1'b1
    } ofs_sel_e;

    typedef enum logic [1:0] {
        WOP_IDLE = 2'd0,
        WOP_PUSH = 2'd1,
        WOP_LOAD = 2'd2
    } wr_op_e;

    typedef enum logic [1:0] {
        ROP_IDLE = 2'd0,
        ROP_POP  = 2'd1,
        ROP_PEEK = 2'd2
    } rd_op_e;

endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pf_mem.sv
module pf_mem #(
    parameter int DW = 18,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdat,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdat
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdat;
        end
    end

    assign rdat = cells[raddr];
endmodule

// File: rtl/pf_wr_ctrl.sv
module pf_wr_ctrl
    import pf_fifo_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 4,
    parameter int OW = 16
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wen_n,
    input  logic          cfg_sel_n,
    input  logic [DW-1:0] wdata,
    input  logic [AW:0]   rgray_s,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW:0]   wgray,
    output logic          full_n,
    output logic          afull_n,
    output logic [OW-1:0] empty_ofs,
    output logic [OW-1:0] full_ofs
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [OW-1:0] DEF_OFS = OW'(DEPTH / 8);

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    wr_op_e        op;
    ofs_sel_e      sel_q;
    ofs_sel_e      sel_d;
    logic [PW-1:0] wbin_q;
    logic [PW-1:0] wbin_d;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] used_now;
    logic [PW-1:0] used_d;
    logic [PW-1:0] free_d;
    logic          full_d;
    logic          afull_d;

    // Operation decode for this write edge
    always_comb begin
        op = WOP_IDLE;
        if (!wen_n) begin
            if (!cfg_sel_n) begin
                op = WOP_LOAD;
            end else if (full_n) begin
                op = WOP_PUSH;
            end
        end
    end

    // Next-state logic: pointer, sequence position, flags
    always_comb begin
        rbin_s   = gray_to_bin(rgray_s);
        wbin_d   = wbin_q + PW'(op == WOP_PUSH);
        used_now = wbin_q - rbin_s;
        used_d   = wbin_d - rbin_s;
        free_d   = DEPTH_P - used_d;
        full_d   = (used_d == DEPTH_P);
        afull_d  = ({{(OW + 1 - PW){1'b0}}, free_d} <= {1'b0, full_ofs});
        sel_d    = sel_q;
        unique case (sel_q)
            SEL_EMPTY_OFS: if (op == WOP_LOAD) sel_d = SEL_FULL_OFS;
            SEL_FULL_OFS:  if (op == WOP_LOAD) sel_d = SEL_EMPTY_OFS;
        endcase
    end

    // State register
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= SEL_EMPTY_OFS;
            wbin_q    <= '0;
            wgray     <= '0;
            full_n    <= 1'b1;
            afull_n   <= 1'b1;
            empty_ofs <= DEF_OFS;
            full_ofs  <= DEF_OFS;
        end else begin
            sel_q   <= sel_d;
            wbin_q  <= wbin_d;
            wgray   <= wbin_d ^ (wbin_d >> 1);
            full_n  <= !full_d;
            afull_n <= !afull_d;
            if (op == WOP_LOAD) begin
                unique case (sel_q)
                    SEL_EMPTY_OFS: empty_ofs <= wdata[OW-1:0];
                    SEL_FULL_OFS:  full_ofs  <= wdata[OW-1:0];
                endcase
            end
        end
    end

    // Outputs toward storage
    always_comb begin
        mem_we    = (op == WOP_PUSH);
        mem_waddr = wbin_q[AW-1:0];
    end

    assert_no_overflow_R4 : assert property (@(posedge wclk) disable iff (!rst_n)
        used_now <= DEPTH_P);

    assert_blocked_when_full_R4 : assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && !wen_n && cfg_sel_n) |=> $stable(wbin_q));

    assert_full_implies_afull_R11 : assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    assert_load_alternates_R7 : assert property (@(posedge wclk) disable iff (!rst_n)
        (!cfg_sel_n && !wen_n) |=> (sel_q != $past(sel_q)));

    assert_load_keeps_ptr_R8 : assert property (@(posedge wclk) disable iff (!rst_n)
        !cfg_sel_n |=> $stable(wbin_q));
endmodule

// File: rtl/pf_rd_ctrl.sv
module pf_rd_ctrl
    import pf_fifo_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 4,
    parameter int OW = 16
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          ren_n,
    input  logic          cfg_sel_n,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_rdat,
    input  logic [OW-1:0] empty_ofs,
    input  logic [OW-1:0] full_ofs,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] out_q,
    output logic          empty_n,
    output logic          aempty_n
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    rd_op_e        op;
    ofs_sel_e      sel_q;
    ofs_sel_e      sel_d;
    logic [PW-1:0] rbin_q;
    logic [PW-1:0] rbin_d;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] avail_now;
    logic [PW-1:0] avail_d;
    logic          aempty_d;
    logic [DW-1:0] out_d;
    logic [OW-1:0] peek_val;

    // Operation decode for this read edge
    always_comb begin
        op = ROP_IDLE;
        if (!ren_n) begin
            if (!cfg_sel_n) begin
                op = ROP_PEEK;
            end else if (empty_n) begin
                op = ROP_POP;
            end
        end
    end

    // Next-state logic: pointer, sequence position, flags, output word
    always_comb begin
        wbin_s    = gray_to_bin(wgray_s);
        rbin_d    = rbin_q + PW'(op == ROP_POP);
        avail_now = wbin_s - rbin_q;
        avail_d   = wbin_s - rbin_d;
        aempty_d  = ({{(OW + 1 - PW){1'b0}}, avail_d} <= {1'b0, empty_ofs});
        sel_d     = sel_q;
        peek_val  = empty_ofs;
        unique case (sel_q)
            SEL_EMPTY_OFS: begin
                peek_val = empty_ofs;
                if (op == ROP_PEEK) sel_d = SEL_FULL_OFS;
            end
            SEL_FULL_OFS: begin
                peek_val = full_ofs;
                if (op == ROP_PEEK) sel_d = SEL_EMPTY_OFS;
            end
        endcase
        unique case (op)
            ROP_POP:  out_d = mem_rdat;
            ROP_PEEK: out_d = {{(DW - OW){1'b0}}, peek_val};
            default:  out_d = out_q;
        endcase
    end

    // State register
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= SEL_EMPTY_OFS;
            rbin_q   <= '0;
            rgray    <= '0;
            out_q    <= '0;
            empty_n  <= 1'b0;
            aempty_n <= 1'b0;
        end else begin
            sel_q    <= sel_d;
            rbin_q   <= rbin_d;
            rgray    <= rbin_d ^ (rbin_d >> 1);
            out_q    <= out_d;
            empty_n  <= (avail_d != '0);
            aempty_n <= !aempty_d;
        end
    end

    assign mem_raddr = rbin_q[AW-1:0];

    assert_no_underflow_R5 : assert property (@(posedge rclk) disable iff (!rst_n)
        avail_now <= DEPTH_P);

    assert_hold_on_empty_R6 : assert property (@(posedge rclk) disable iff (!rst_n)
        (!empty_n && !ren_n && cfg_sel_n) |=> $stable(out_q));

    assert_empty_implies_aempty_R10 : assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    assert_peek_alternates_R9 : assert property (@(posedge rclk) disable iff (!rst_n)
        (!cfg_sel_n && !ren_n) |=> (sel_q != $past(sel_q)));

    assert_peek_keeps_ptr_R8 : assert property (@(posedge rclk) disable iff (!rst_n)
        !cfg_sel_n |=> $stable(rbin_q));
endmodule

// File: rtl/pf_fifo_top.sv
module pf_fifo_top #(
    parameter int DEPTH = 16,
    parameter int DW    = 18,
    parameter int OW    = 16
) (
    input  logic          rst_n,
    input  logic          wclk,
    input  logic          wen_n,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          ren_n,
    input  logic          cfg_sel_n,
    input  logic          oe_n,
    output logic [DW-1:0] rdata,
    output logic          empty_n,
    output logic          aempty_n,
    output logic          full_n,
    output logic          afull_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wgray_s;
    logic [PW-1:0] rgray_s;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [AW-1:0] mem_raddr;
    logic [DW-1:0] mem_rdat;
    logic [OW-1:0] empty_ofs;
    logic [OW-1:0] full_ofs;
    logic [DW-1:0] out_q;

    pf_mem #(.DW(DW), .AW(AW)) mem_i (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdat  (wdata),
        .raddr (mem_raddr),
        .rdat  (mem_rdat)
    );

    pf_wr_ctrl #(.DW(DW), .AW(AW), .OW(OW)) wr_i (
        .wclk      (wclk),
        .rst_n     (rst_n),
        .wen_n     (wen_n),
        .cfg_sel_n (cfg_sel_n),
        .wdata     (wdata),
        .rgray_s   (rgray_s),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .wgray     (wgray),
        .full_n    (full_n),
        .afull_n   (afull_n),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    pf_sync #(.W(PW)) w2r_i (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    pf_sync #(.W(PW)) r2w_i (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    pf_rd_ctrl #(.DW(DW), .AW(AW), .OW(OW)) rd_i (
        .rclk      (rclk),
        .rst_n     (rst_n),
        .ren_n     (ren_n),
        .cfg_sel_n (cfg_sel_n),
        .wgray_s   (wgray_s),
        .mem_rdat  (mem_rdat),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .mem_raddr (mem_raddr),
        .rgray     (rgray),
        .out_q     (out_q),
        .empty_n   (empty_n),
        .aempty_n  (aempty_n)
    );

    assign rdata = oe_n ? {DW{1'bz}} : out_q;
endmodule

// File: tb/pf_fifo_top_tb_top.sv
module pf_fifo_top_tb_top;
    localparam int D = 16;

    logic        rst_n = 1'b0;
    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        wen_n = 1'b1;
    logic        ren_n = 1'b1;
    logic        cfg_sel_n = 1'b1;
    logic        oe_n = 1'b0;
    logic [17:0] wdata = '0;
    wire  [17:0] rdata;
    logic        empty_n, aempty_n, full_n, afull_n;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit mon_on = 0;

    logic [17:0] q[$];
    logic [17:0] last_rd = '0;
    int eo = 2;
    int fo = 2;
    bit wpos = 0;
    bit rpos = 0;

    pf_fifo_top dut_i (
        .rst_n(rst_n), .wclk(wclk), .wen_n(wen_n), .wdata(wdata),
        .rclk(rclk), .ren_n(ren_n), .cfg_sel_n(cfg_sel_n), .oe_n(oe_n),
        .rdata(rdata), .empty_n(empty_n), .aempty_n(aempty_n),
        .full_n(full_n), .afull_n(afull_n)
    );

    always #4 wclk = ~wclk;
    initial begin
        #3;
        forever #4 rclk = ~rclk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-edge boundary-flag safety against the model
    always @(negedge rclk) begin
        if (mon_on && q.size() == 0) begin
            chk(empty_n == 1'b0, "R12", "empty_n while model empty", 32'(empty_n), 0);
        end
    end
    always @(negedge wclk) begin
        if (mon_on && q.size() == D) begin
            chk(full_n == 1'b0, "R12", "full_n while model full", 32'(full_n), 0);
        end
    end

    task automatic wr_word(input logic [17:0] d);
        bit ok;
        @(negedge wclk);
        cfg_sel_n = 1'b1;
        wdata = d;
        wen_n = 1'b0;
        ok = full_n;
        @(posedge wclk);
        if (ok) q.push_back(d);
        @(negedge wclk);
        wen_n = 1'b1;
    endtask

    task automatic wr_ofs(input int v);
        @(negedge wclk);
        cfg_sel_n = 1'b0;
        wdata = 18'(v) | 18'h30000;
        wen_n = 1'b0;
        @(posedge wclk);
        if (wpos == 0) eo = v; else fo = v;
        wpos = ~wpos;
        @(negedge wclk);
        wen_n = 1'b1;
        cfg_sel_n = 1'b1;
    endtask

    task automatic rd_word(input string req);
        bit ok;
        logic [17:0] exp;
        @(negedge rclk);
        cfg_sel_n = 1'b1;
        ren_n = 1'b0;
        ok = empty_n;
        @(posedge rclk);
        #1;
        if (ok) begin
            exp = q.pop_front();
            chk(rdata === exp, req, "read word", 32'(rdata), 32'(exp));
            last_rd = exp;
        end else begin
            chk(rdata === last_rd, "R6", "hold on empty read", 32'(rdata), 32'(last_rd));
        end
        @(negedge rclk);
        ren_n = 1'b1;
    endtask

    task automatic rd_ofs(input string req);
        int exp;
        @(negedge rclk);
        cfg_sel_n = 1'b0;
        ren_n = 1'b0;
        @(posedge rclk);
        #1;
        exp = rpos ? fo : eo;
        chk(rdata === 18'(exp), req, "offset readback", 32'(rdata), 32'(exp));
        rpos = ~rpos;
        @(negedge rclk);
        ren_n = 1'b1;
        cfg_sel_n = 1'b1;
    endtask

    task automatic settle(input string req);
        int n;
        repeat (10) @(negedge wclk);
        n = q.size();
        chk(full_n == (n != D), req, "full_n settled", 32'(full_n), 32'(n != D));
        chk(empty_n == (n != 0), req, "empty_n settled", 32'(empty_n), 32'(n != 0));
        chk(afull_n == !((D - n) <= fo), "R11", "afull_n settled",
            32'(afull_n), 32'(!((D - n) <= fo)));
        chk(aempty_n == !(n <= eo), "R10", "aempty_n settled",
            32'(aempty_n), 32'(!(n <= eo)));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge wclk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(empty_n == 0, "R1", "empty_n after reset", 32'(empty_n), 0);
        chk(full_n == 1, "R1", "full_n after reset", 32'(full_n), 1);
        chk(aempty_n == 0, "R1", "aempty_n after reset", 32'(aempty_n), 0);
        chk(afull_n == 1, "R1", "afull_n after reset", 32'(afull_n), 1);
        chk(rdata === 18'h0, "R1", "rdata after reset", 32'(rdata), 0);
        mon_on = 1;

        // R1 / R9 default offsets read back in order
        rd_ofs("R1");
        rd_ofs("R9");

        // R7 load empty then full offset; R9 read back
        wr_ofs(3);
        wr_ofs(5);
        rd_ofs("R7");
        rd_ofs("R7");
        settle("R5");

        // R10 almost-empty boundary
        for (int i = 0; i < 3; i++) wr_word(18'h10000 + 18'(i));
        settle("R10");
        wr_word(18'h10003);
        settle("R10");

        // R11 almost-full boundary
        for (int i = 4; i < 10; i++) wr_word(18'h10000 + 18'(i));
        settle("R11");
        wr_word(18'h1000A);
        settle("R11");

        // R4 fill, then writes past full are dropped
        for (int i = 11; i < 16; i++) wr_word(18'h10000 + 18'(i));
        settle("R4");
        for (int i = 0; i < 3; i++) wr_word(18'h3FFF0 + 18'(i));
        settle("R4");

        // R2 drain in order; R5 / R6 reads past empty
        while (q.size() > 0) rd_word("R2");
        settle("R5");
        rd_word("R6");
        rd_word("R5");

        // R3 output enable
        @(negedge rclk);
        oe_n = 1'b1;
        #1;
        chk(rdata === {18{1'bz}}, "R3", "rdata disabled", 32'(rdata), 32'h0);
        oe_n = 1'b0;
        #1;
        chk(rdata === last_rd, "R3", "rdata re-enabled", 32'(rdata), 32'(last_rd));

        // R8 offset access mixed with stored words
        wr_word(18'h2AAAA);
        wr_word(18'h15555);
        wr_ofs(1);
        rd_ofs("R8");
        settle("R8");
        wr_ofs(7);
        rd_ofs("R8");
        settle("R8");
        rd_word("R8");
        rd_word("R8");
        settle("R8");

        // R2 / R12 both ports busy
        fork
            for (int i = 0; i < 60; i++) begin
                wr_word(18'(i * 7919 + 5));
                if (i % 7 == 3) repeat (3) @(negedge wclk);
            end
            for (int i = 0; i < 60; i++) begin
                rd_word("R2");
                if (i % 5 == 1) repeat (2) @(negedge rclk);
            end
        join
        while (q.size() > 0) rd_word("R2");
        settle("R12");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule